// File: doc/BRIEF.md
# Processor Clock and Low-Power Mode Controller

This block sits between a free-running oscillator and the processor core. It decides whether the oscillator runs, how often the core receives a clock-enable strobe, and which peripherals receive their own gated strobes. Software writes a small register set over a simple synchronous write port. Through it, software picks one of six core divide ratios, sets up each peripheral's enable and divide ratio, programs a stabilization wait, and requests one of two sleep modes. A combinational read port returns the configuration and a status word.

The two sleep modes differ in what stays powered and in what ends them. In the light sleep mode the core strobe stops, but the oscillator and the enabled peripherals keep running. Any interrupt, internal or external, resumes the core on the next cycle. In the deep sleep mode the oscillator is switched off and every strobe stops. Only an external interrupt ends it. That exit passes through a waking state, which keeps the core gated until a programmed number of cycles have elapsed and the oscillator reports ready.

Top module: `pm_clock_ctrl`

## Requirements
- R1: After reset the mode is RUN, the applied core divide select is 0, the oscillator enable is 1, the last wake source is 0, and `cpuClkEn` is high on every cycle.
- R2: Core divide select values 0 to 5 (write address 0, bits [2:0]) give divide ratios of 1, 2, 4, 8, 16 and 32. Once a value is applied, `cpuClkEn` pulses once every 2^select cycles in RUN.
- R3: Writing divide select 6 or 7 has no effect, and the previously applied ratio stays in force.
- R4: A new divide select takes effect only on the cycle after the free-running 5-bit divider counter reaches 31. Successive changes of `cpuDivSel` are therefore a multiple of 32 cycles apart.
- R5: In RUN, a write to address 0 with bits [5:4] equal to 01 enters HALT on the next cycle. In HALT `cpuClkEn` is 0 and `oscEn` stays 1.
- R6: In HALT, a high `extIrq` or `intIrq` returns the block to RUN on the next cycle, with no wait. The wake source reads 1 when `extIrq` was high (external takes priority) and 2 otherwise.
- R7: In RUN, a write to address 0 with bits [5:4] equal to 10 enters STANDBY. There `oscEn`, `cpuClkEn` and all `periphClkEn` bits are 0.
- R8: In STANDBY, `intIrq` is ignored and the mode stays STANDBY.
- R9: Peripheral i pulses `periphClkEn[i]` in RUN and HALT only when its enable bit (address 2, bit i) is set. It pulses once every 2^r cycles, where r is the 2-bit field at address 2, bits [4+2i+1:4+2i].
- R10: In STANDBY, a high `extIrq` enters WAKING, where `oscEn` is 1 and `cpuClkEn` is 0. With L being the value at address 1, the block stays in WAKING for L+1 cycles, and longer while `oscReady` is low. It then enters RUN with wake source 1.
- R11: Reading address 3 returns the status word: [1:0] mode (RUN 0, HALT 1, STANDBY 2, WAKING 3), [3:2] last wake source, and [6:4] applied core divide select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 16 | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | 16 | Register read data (combinational) |
| extIrq | input | 1 | External interrupt request, level |
| intIrq | input | 1 | Internal interrupt request, level |
| oscEn | output | 1 | Oscillator enable |
| oscReady | input | 1 | Oscillator reports stable output |
| cpuDivSel | output | 3 | Applied core divide select |
| cpuClkEn | output | 1 | Core clock-enable strobe |
| periphClkEn | output | 4 | Per-peripheral clock-enable strobes |

## Verification
The bench writes a divide select of 6 right after a legal one. A controller that accepted it would report an unknown ratio and stop pulsing the core. The bench then times two successive ratio changes against each other. A divider that switched ratios mid-period would shorten a core pulse and place the changes at spacings that are not multiples of 32. In STANDBY the bench asserts only the internal interrupt, which a controller that filtered wake sources wrongly would answer by waking the core on a stopped oscillator. The bench also counts the WAKING cycles and holds `oscReady` low, so an off-by-one wait or an ignored ready input shows up as a wrong cycle count or an early return to RUN.

// File: rtl/pm_pkg.sv
package pm_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_HALT = 2'd1,
    MODE_STBY = 2'd2,
    MODE_WAKE = 2'd3
  } pmMode_t;

  localparam logic [1:0] WAKE_NONE = 2'd0;
  localparam logic [1:0] WAKE_EXT  = 2'd1;
  localparam logic [1:0] WAKE_INT  = 2'd2;

  localparam logic [1:0] REQ_HALT = 2'b01;
  localparam logic [1:0] REQ_STBY = 2'b10;

  // Strobes from the mode control to the clocking datapath
  typedef struct packed {
    logic cpuRun;     // core strobe allowed
    logic periphRun;  // peripheral strobes allowed
    logic stabClr;    // hold stabilization counter at zero
    logic stabInc;    // advance stabilization counter
  } pmStrobe_t;

endpackage

// File: rtl/pm_regs.sv
module pm_regs
  import pm_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int DIV_STEPS  = 6,
  parameter int NUM_PERIPH = 4,
  parameter int RATIO_W    = 2,
  parameter int STAB_W     = 16,
  parameter logic [STAB_W-1:0] STAB_RESET = 16'd200
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wrEn,
  input  logic [1:0]                    wrAddr,
  input  logic [DATA_W-1:0]             wrData,
  input  logic [1:0]                    rdAddr,
  output logic [DATA_W-1:0]             rdData,
  input  pmMode_t                       modeIn,
  input  logic [1:0]                    wakeSrcIn,
  input  logic [$clog2(DIV_STEPS)-1:0]  appliedDivIn,
  output logic [$clog2(DIV_STEPS)-1:0]  pendingDiv,
  output logic [STAB_W-1:0]             stabLimit,
  output logic [NUM_PERIPH-1:0]         periphEn,
  output logic [NUM_PERIPH*RATIO_W-1:0] periphRatio,
  output logic                          haltReq,
  output logic                          stbyReq
);

  localparam int SEL_W   = $clog2(DIV_STEPS);
  localparam int CFG_W   = NUM_PERIPH * (1 + RATIO_W);
  localparam int RATIO_LO = NUM_PERIPH;

  logic ctrlWr, stabWr, perWr;
  logic [SEL_W-1:0] selField;
  logic [1:0] reqField;
  logic [CFG_W-1:0] perCfg;

  assign ctrlWr   = wrEn && (wrAddr == 2'd0);
  assign stabWr   = wrEn && (wrAddr == 2'd1);
  assign perWr    = wrEn && (wrAddr == 2'd2);
  assign selField = wrData[SEL_W-1:0];
  assign reqField = wrData[5:4];

  assign haltReq = ctrlWr && (reqField == REQ_HALT);
  assign stbyReq = ctrlWr && (reqField == REQ_STBY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pendingDiv <= '0;
      stabLimit  <= STAB_RESET;
      perCfg     <= '0;
    end else begin
      // out-of-range selects are dropped, keeping the previous ratio
      if (ctrlWr && (int'(selField) < DIV_STEPS)) pendingDiv <= selField;
      if (stabWr) stabLimit <= wrData[STAB_W-1:0];
      if (perWr)  perCfg    <= wrData[CFG_W-1:0];
    end
  end

  assign periphEn    = perCfg[NUM_PERIPH-1:0];
  assign periphRatio = perCfg[CFG_W-1:RATIO_LO];

  always_comb begin
    rdData = '0;
    case (rdAddr)
      2'd0: rdData = DATA_W'(pendingDiv);
      2'd1: rdData = DATA_W'(stabLimit);
      2'd2: rdData = DATA_W'(perCfg);
      default: begin
        rdData[1:0] = modeIn;
        rdData[3:2] = wakeSrcIn;
        rdData[4 +: SEL_W] = appliedDivIn;
      end
    endcase
  end

  AST_PENDING_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pendingDiv) < DIV_STEPS);  // R3

endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import pm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      haltReq,
  input  logic      stbyReq,
  input  logic      extIrq,
  input  logic      intIrq,
  input  logic      oscReady,
  input  logic      stabDone,
  output pmMode_t   mode,
  output logic [1:0] wakeSrc,
  output logic      oscEn,
  output pmStrobe_t strb
);

  pmMode_t modeNext;
  logic [1:0] wakeNext;

  always_comb begin
    modeNext = mode;
    wakeNext = wakeSrc;
    case (mode)
      MODE_RUN: begin
        if (stbyReq)      modeNext = MODE_STBY;
        else if (haltReq) modeNext = MODE_HALT;
      end
      MODE_HALT: begin
        // any interrupt resumes at once, external reported first
        if (extIrq) begin
          modeNext = MODE_RUN;
          wakeNext = WAKE_EXT;
        end else if (intIrq) begin
          modeNext = MODE_RUN;
          wakeNext = WAKE_INT;
        end
      end
      MODE_STBY: begin
        // internal requests are filtered out here
        if (extIrq) begin
          modeNext = MODE_WAKE;
          wakeNext = WAKE_EXT;
        end
      end
      default: begin
        if (stabDone && oscReady) modeNext = MODE_RUN;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= MODE_RUN;
      wakeSrc <= WAKE_NONE;
    end else begin
      mode    <= modeNext;
      wakeSrc <= wakeNext;
    end
  end

  assign oscEn          = (mode != MODE_STBY);
  assign strb.cpuRun    = (mode == MODE_RUN);
  assign strb.periphRun = (mode == MODE_RUN) || (mode == MODE_HALT);
  assign strb.stabClr   = (mode != MODE_WAKE);
  assign strb.stabInc   = (mode == MODE_WAKE);

  AST_HALT_FAST_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HALT && (extIrq || intIrq)) |=> (mode == MODE_RUN));  // R6

  AST_STBY_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STBY && !extIrq) |=> (mode == MODE_STBY));  // R8

  AST_WAKE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_WAKE && !oscReady) |=> (mode == MODE_WAKE));  // R10

  AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RUN && haltReq && !stbyReq) |=> (mode == MODE_HALT));  // R5

endmodule

// File: rtl/pm_datapath.sv
module pm_datapath
  import pm_pkg::*;
#(
  parameter int DIV_STEPS  = 6,
  parameter int NUM_PERIPH = 4,
  parameter int RATIO_W    = 2,
  parameter int STAB_W     = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  pmStrobe_t                     strb,
  input  logic [$clog2(DIV_STEPS)-1:0]  pendingDiv,
  input  logic [STAB_W-1:0]             stabLimit,
  input  logic [NUM_PERIPH-1:0]         periphEn,
  input  logic [NUM_PERIPH*RATIO_W-1:0] periphRatio,
  output logic                          cpuClkEn,
  output logic [$clog2(DIV_STEPS)-1:0]  cpuDivSel,
  output logic [NUM_PERIPH-1:0]         periphClkEn,
  output logic                          stabDone
);

  localparam int CNT_W = DIV_STEPS - 1;
  localparam int SEL_W = $clog2(DIV_STEPS);

  logic [CNT_W-1:0]  divCnt;
  logic [SEL_W-1:0]  appliedDiv;
  logic [STAB_W-1:0] stabCnt;
  logic [CNT_W-1:0]  cpuMask;
  logic              atTerminal;

  function automatic logic [CNT_W-1:0] lowMask(input int bits);
    logic [CNT_W-1:0] m;
    for (int b = 0; b < CNT_W; b++) m[b] = (b < bits);
    return m;
  endfunction

  assign atTerminal = (divCnt == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      divCnt     <= '0;
      appliedDiv <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
      // ratio switches only at the end of the slowest period
      if (atTerminal) appliedDiv <= pendingDiv;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stabCnt <= '0;
    end else if (strb.stabClr) begin
      stabCnt <= '0;
    end else if (strb.stabInc && (stabCnt != '1)) begin
      stabCnt <= stabCnt + 1'b1;
    end
  end

  assign stabDone  = (stabCnt >= stabLimit);
  assign cpuMask   = lowMask(int'(appliedDiv));
  assign cpuClkEn  = strb.cpuRun && ((divCnt & cpuMask) == cpuMask);
  assign cpuDivSel = appliedDiv;

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : gPeriph
    logic [RATIO_W-1:0] ratio;
    logic [CNT_W-1:0]   pMask;
    assign ratio = periphRatio[i*RATIO_W +: RATIO_W];
    assign pMask = lowMask(int'(ratio));
    assign periphClkEn[i] = strb.periphRun && periphEn[i] &&
                            ((divCnt & pMask) == pMask);
  end

  AST_DIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    int'(appliedDiv) < DIV_STEPS);  // R3

  AST_DIV_AT_TERMINAL: assert property (@(posedge clk) disable iff (!rst_n)
    (appliedDiv != $past(appliedDiv)) |-> ($past(divCnt) == '1));  // R4

endmodule

// File: rtl/pm_clock_ctrl.sv
module pm_clock_ctrl
  import pm_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int DIV_STEPS  = 6,
  parameter int NUM_PERIPH = 4,
  parameter int RATIO_W    = 2,
  parameter int STAB_W     = 16,
  parameter logic [STAB_W-1:0] STAB_RESET = 16'd200
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wrEn,
  input  logic [1:0]                   wrAddr,
  input  logic [DATA_W-1:0]            wrData,
  input  logic [1:0]                   rdAddr,
  output logic [DATA_W-1:0]            rdData,
  input  logic                         extIrq,
  input  logic                         intIrq,
  output logic                         oscEn,
  input  logic                         oscReady,
  output logic [$clog2(DIV_STEPS)-1:0] cpuDivSel,
  output logic                         cpuClkEn,
  output logic [NUM_PERIPH-1:0]        periphClkEn
);

  localparam int SEL_W = $clog2(DIV_STEPS);

  pmMode_t   mode;
  pmStrobe_t strb;
  logic [1:0] wakeSrc;
  logic [SEL_W-1:0] pendingDiv;
  logic [STAB_W-1:0] stabLimit;
  logic [NUM_PERIPH-1:0] periphEn;
  logic [NUM_PERIPH*RATIO_W-1:0] periphRatio;
  logic haltReq, stbyReq, stabDone;

  pm_regs #(
    .DATA_W(DATA_W), .DIV_STEPS(DIV_STEPS), .NUM_PERIPH(NUM_PERIPH),
    .RATIO_W(RATIO_W), .STAB_W(STAB_W), .STAB_RESET(STAB_RESET)
  ) uRegs (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .modeIn(mode), .wakeSrcIn(wakeSrc),
    .appliedDivIn(cpuDivSel), .pendingDiv(pendingDiv), .stabLimit(stabLimit),
    .periphEn(periphEn), .periphRatio(periphRatio),
    .haltReq(haltReq), .stbyReq(stbyReq)
  );

  pm_ctrl uCtrl (
    .clk(clk), .rst_n(rst_n), .haltReq(haltReq), .stbyReq(stbyReq),
    .extIrq(extIrq), .intIrq(intIrq), .oscReady(oscReady), .stabDone(stabDone),
    .mode(mode), .wakeSrc(wakeSrc), .oscEn(oscEn), .strb(strb)
  );

  pm_datapath #(
    .DIV_STEPS(DIV_STEPS), .NUM_PERIPH(NUM_PERIPH),
    .RATIO_W(RATIO_W), .STAB_W(STAB_W)
  ) uPath (
    .clk(clk), .rst_n(rst_n), .strb(strb), .pendingDiv(pendingDiv),
    .stabLimit(stabLimit), .periphEn(periphEn), .periphRatio(periphRatio),
    .cpuClkEn(cpuClkEn), .cpuDivSel(cpuDivSel), .periphClkEn(periphClkEn),
    .stabDone(stabDone)
  );

  AST_NO_STROBE_WITHOUT_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    !oscEn |-> (!cpuClkEn && (periphClkEn == '0)));  // R7

endmodule

// File: tb/tb_pm_clock_ctrl.sv
module tb_pm_clock_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [1:0] rdAddr = 2'd3;
  logic [15:0] rdData;
  logic extIrq = 1'b0, intIrq = 1'b0, oscReady = 1'b1;
  logic oscEn, cpuClkEn;
  logic [2:0] cpuDivSel;
  logic [3:0] periphClkEn;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    string req;
    int sel;
    int exp;
    int act;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pm_clock_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .extIrq(extIrq), .intIrq(intIrq),
    .oscEn(oscEn), .oscReady(oscReady), .cpuDivSel(cpuDivSel),
    .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn)
  );

  function automatic int observe(int sel);
    case (sel)
      0: return int'(rdData[1:0]);
      1: return int'(rdData[3:2]);
      2: return int'(rdData[6:4]);
      3: return int'(oscEn);
      4: return int'(cpuClkEn);
      5: return int'(cpuDivSel);
      6: return int'(periphClkEn);
      default: return -1;
    endcase
  endfunction

  // driver side: push expectations, monitor compares after the edge settles
  task automatic expectPort(string req, int sel, int exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp; it.act = 0;
    sb.push_back(it);
  endtask

  task automatic expectVal(string req, int act, int exp);
    item_t it;
    it.req = req; it.sel = 9; it.exp = exp; it.act = act;
    sb.push_back(it);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb.size() > 0) begin
        item_t it;
        int got;
        it = sb.pop_front();
        got = (it.sel == 9) ? it.act : observe(it.sel);
        checks++;
        if (got != it.exp) begin
          failures++;
          $display("FAIL %s sel=%0d actual=%0d expected=%0d", it.req, it.sel, got, it.exp);
        end
      end
    end
  end

  task automatic regWrite(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic gapOf(int which, output int gap);
    int n;
    gap = -1;
    n = 0;
    while (n < 100) begin
      @(negedge clk); #1;
      if ((which == 0) ? cpuClkEn : periphClkEn[which-1]) break;
      n++;
    end
    for (int k = 1; k < 100; k++) begin
      @(negedge clk); #1;
      if ((which == 0) ? cpuClkEn : periphClkEn[which-1]) begin
        gap = k;
        break;
      end
    end
  endtask

  task automatic countPulses(int cycles, output int cpuN, output int perN);
    cpuN = 0; perN = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk); #1;
      cpuN += int'(cpuClkEn);
      perN += $countones(periphClkEn);
    end
  endtask

  initial begin
    int g, cN, pN, t1, t2, wakeLen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expectPort("R1 mode", 0, 0);
    expectPort("R1 wakeSrc", 1, 0);
    expectPort("R1 div", 5, 0);
    expectPort("R1 oscEn", 3, 1);
    gapOf(0, g);
    expectVal("R1 cpu gap", g, 1);

    // R2 divide by 8, R11 status reports it
    regWrite(2'd0, 16'h0003);
    repeat (70) @(negedge clk);
    expectPort("R11 status div", 2, 3);
    expectPort("R2 div", 5, 3);
    gapOf(0, g);
    expectVal("R2 gap sel3", g, 8);
    regWrite(2'd0, 16'h0005);
    repeat (70) @(negedge clk);
    gapOf(0, g);
    expectVal("R2 gap sel5", g, 32);

    // R3 illegal select ignored
    regWrite(2'd0, 16'h0006);
    repeat (70) @(negedge clk);
    expectPort("R3 div kept", 5, 5);
    regWrite(2'd0, 16'h0007);
    repeat (70) @(negedge clk);
    gapOf(0, g);
    expectVal("R3 gap kept", g, 32);

    // R4 change spacing is a multiple of 32
    regWrite(2'd0, 16'h0001);
    while (cpuDivSel != 3'd1) @(negedge clk);
    t1 = cyc;
    regWrite(2'd0, 16'h0004);
    while (cpuDivSel != 3'd4) @(negedge clk);
    t2 = cyc;
    expectVal("R4 spacing mod 32", (t2 - t1) % 32, 0);
    regWrite(2'd0, 16'h0000);
    repeat (40) @(negedge clk);

    // R9 peripherals: p0 every cycle, p1 every 4, others off
    regWrite(2'd2, 16'h0083);
    gapOf(1, g);
    expectVal("R9 p0 gap", g, 1);
    gapOf(2, g);
    expectVal("R9 p1 gap", g, 4);
    pN = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); #1;
      pN += int'(periphClkEn[2]) + int'(periphClkEn[3]);
    end
    expectVal("R9 disabled silent", pN, 0);

    // R5 HALT entry
    regWrite(2'd0, 16'h0010);
    expectPort("R5 mode halt", 0, 1);
    expectPort("R5 oscEn", 3, 1);
    countPulses(16, cN, pN);
    expectVal("R5 cpu gated", cN, 0);
    expectVal("R9 periph runs in halt", pN, 16 + 4);

    // R6 internal wake
    @(negedge clk);
    intIrq = 1'b1;
    @(negedge clk);
    intIrq = 1'b0;
    expectPort("R6 run after int", 0, 0);
    expectPort("R6 src int", 1, 2);
    // R6 both sources, external wins
    regWrite(2'd0, 16'h0010);
    extIrq = 1'b1; intIrq = 1'b1;
    @(negedge clk);
    extIrq = 1'b0; intIrq = 1'b0;
    expectPort("R6 run after both", 0, 0);
    expectPort("R6 src ext", 1, 1);

    // R7 STANDBY, R8 intIrq ignored
    regWrite(2'd1, 16'd10);
    regWrite(2'd0, 16'h0020);
    expectPort("R7 mode stby", 0, 2);
    expectPort("R7 oscEn off", 3, 0);
    intIrq = 1'b1;
    countPulses(8, cN, pN);
    intIrq = 1'b0;
    expectVal("R7 cpu off", cN, 0);
    expectVal("R7 periph off", pN, 0);
    expectPort("R8 still stby", 0, 2);

    // R10 external wake and stabilization length
    extIrq = 1'b1;
    @(negedge clk);
    extIrq = 1'b0;
    expectPort("R10 waking", 0, 3);
    expectPort("R10 osc on", 3, 1);
    expectPort("R10 cpu gated", 4, 0);
    wakeLen = 0;
    while (rdData[1:0] == 2'd3 && wakeLen < 100) begin
      wakeLen++;
      @(negedge clk); #1;
    end
    expectVal("R10 wake cycles", wakeLen, 11);
    expectPort("R10 run", 0, 0);
    expectPort("R10 src ext", 1, 1);

    // R10 oscReady low holds WAKING
    regWrite(2'd1, 16'd3);
    regWrite(2'd0, 16'h0020);
    oscReady = 1'b0;
    extIrq = 1'b1;
    @(negedge clk);
    extIrq = 1'b0;
    countPulses(20, cN, pN);
    expectVal("R10 no cpu while unready", cN, 0);
    expectPort("R10 held waking", 0, 3);
    oscReady = 1'b1;
    @(negedge clk);
    expectPort("R10 run after ready", 0, 0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule